// File: doc/BRIEF.md
# Hardware Page Table Walker

This block resolves a translation-cache miss without help from software. It takes one miss at a time, made of a virtual address and an access kind. It then walks a four-level page table that sits in memory, starting at the root table named by an operating-system-written root register. Each level costs one memory read. The address of that read comes from the entry returned by the level before it, so the reads go out strictly one after another over a valid/ready request port and a valid-only response port.

The walk ends in one of two ways. It can produce a single-cycle fill, carrying the leaf page number and the leaf flags, for the translation cache to insert. Or it can produce a single-cycle fault that carries a cause code and the full faulting virtual address. The virtual address has 52 bits: four 10-bit table indices, taken from the most significant end, above a 12-bit page offset. Each entry has 64 bits. Bit 0 is valid, bit 1 is read, bit 2 is write, bit 3 is execute and bit 4 is global. Bits [63:12] hold the next table's page number or the leaf page number.

The controller has five states. IDLE waits for a miss. ISSUE holds a read request until memory accepts it. WAIT waits for the entry. DONE pulses the fill. FAULT pulses the fault. The transitions are:
- IDLE goes to ISSUE on an accepted miss.
- ISSUE goes to WAIT on the request handshake.
- WAIT goes back to ISSUE when the entry is valid and it is not the last level.
- WAIT goes to DONE when the leaf is valid and allows the access.
- WAIT goes to FAULT when the entry is not valid, or when the leaf refuses the access.
- DONE and FAULT both return to IDLE after one cycle.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: req_ready is 1, busy is 0, and mem_req_valid, fill_valid and fault_valid are all 0.
- R2: The cycle after a miss is accepted, the first read is presented at address root_ppn·4096 + req_vaddr[51:42]·8.
- R3: Each later level reads at entry[63:12]·4096 + index·8, where entry is the entry returned by the level before. The indices are vaddr[41:32], vaddr[31:22] and vaddr[21:12] in turn. Only one read is outstanding at a time, and a complete walk makes exactly four reads.
- R4: An entry with bit 0 clear, at any level, ends the walk at once. The walker issues no further reads and pulses fault_valid with fault_cause 0 and fault_vaddr equal to the miss address.
- R5: The leaf is checked against the access kind. Code 0 (load) needs bit 1, code 1 (store) needs bit 2, code 2 (fetch) needs bit 3, and code 3 is treated as a load. A leaf that lacks the needed bit faults with fault_cause 1.
- R6: A walk that succeeds pulses fill_valid for exactly one cycle, with fill_vpn = vaddr[51:12], fill_ppn = leaf[63:12] and fill_flags = leaf[4:0].
- R7: Only one walk runs at a time. busy is 1 and req_ready is 0 from the cycle after acceptance through the result cycle, and req_ready is 1 again in the cycle after the result.
- R8: While mem_req_valid is 1 and mem_req_ready is 0, the request stays valid and its address stays the same in the next cycle.
- R9: Each accepted miss produces exactly one result pulse. fill_valid and fault_valid are never 1 in the same cycle.
- R10: The read, write and execute bits of a non-leaf entry have no effect, and the walk continues through that entry to the next level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Walker can accept a miss |
| req_vaddr | input | 52 | Missing virtual address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| root_ppn | input | 52 | Page number of the root table |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Returned entry |
| fill_valid | output | 1 | Translation ready for insertion |
| fill_vpn | output | 40 | Virtual page number of the fill |
| fill_ppn | output | 52 | Physical page number of the fill |
| fill_flags | output | 5 | Leaf flag bits [4:0] |
| fault_valid | output | 1 | Walk ended in a fault |
| fault_cause | output | 1 | 0 not present, 1 permission refused |
| fault_vaddr | output | 52 | Faulting virtual address |

## Verification
Randomly built tables drive walks that end in one of three ways: a full walk that fills, a walk that stops at a random level on an invalid entry, or a walk whose leaf refuses the access kind. This separates an index-slicing or base-chaining error, which shows up as a wrong read address, from a fault that fires at the wrong level, which shows up as a wrong read count. Directed cases cover the all-ones address, where the index reaches 1023 and the address arithmetic wraps, code 3 treated as a load, and non-leaf entries that carry permission bits. Random memory stalls and random response latency test that the request is held steady and that only one read is outstanding.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE,
        ST_FAULT
    } walk_state_t;

    localparam int FLG_V = 0;
    localparam int FLG_R = 1;
    localparam int FLG_W = 2;
    localparam int FLG_X = 3;
    localparam int FLG_G = 4;

    localparam logic [1:0] ACC_LOAD  = 2'd0;
    localparam logic [1:0] ACC_STORE = 2'd1;
    localparam logic [1:0] ACC_FETCH = 2'd2;
endpackage

// File: rtl/ptw_slice.sv
module ptw_slice #(
    parameter int VA_W      = 52,
    parameter int LVL       = 4,
    parameter int IDX_W     = 10,
    parameter int OFF_W     = 12,
    parameter int PA_W      = 64,
    parameter int ENT_BYTES = 8
) (
    input  logic [VA_W-1:0]         vaddr,
    input  logic [$clog2(LVL)-1:0]  level,
    input  logic [PA_W-OFF_W-1:0]   base_ppn,
    output logic [PA_W-1:0]         entry_addr
);
    localparam int SH = $clog2(ENT_BYTES);

    logic [IDX_W-1:0] idx_tab [LVL];
    logic [IDX_W-1:0] idx;
    logic             unused_off;

    genvar g;
    generate
        for (g = 0; g < LVL; g++) begin : g_slice
            assign idx_tab[g] = vaddr[VA_W-1-g*IDX_W -: IDX_W];
        end
    endgenerate

    assign idx        = idx_tab[level];
    assign entry_addr = {base_ppn, {OFF_W{1'b0}}}
                      + ({{(PA_W-IDX_W){1'b0}}, idx} << SH);
    assign unused_off = ^vaddr[OFF_W-1:0];
endmodule

// File: rtl/ptw_perm.sv
module ptw_perm
    import ptw_pkg::*;
(
    input  logic [1:0] acc,
    input  logic [2:0] rwx,
    output logic       allowed
);
    always_comb begin
        unique case (acc)
            ACC_STORE: allowed = rwx[FLG_W-1];
            ACC_FETCH: allowed = rwx[FLG_X-1];
            default:   allowed = rwx[FLG_R-1];
        endcase
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int VA_W   = 52,
    parameter int LVL    = 4,
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 12,
    parameter int PA_W   = 64,
    parameter int PTE_W  = 64,
    parameter int FLAG_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic [1:0]            req_acc,
    input  logic [PA_W-OFF_W-1:0] root_ppn,
    output logic                  busy,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic [PA_W-1:0]       mem_req_addr,
    input  logic                  mem_rsp_valid,
    input  logic [PTE_W-1:0]      mem_rsp_data,
    output logic                  fill_valid,
    output logic [VA_W-OFF_W-1:0] fill_vpn,
    output logic [PA_W-OFF_W-1:0] fill_ppn,
    output logic [FLAG_W-1:0]     fill_flags,
    output logic                  fault_valid,
    output logic                  fault_cause,
    output logic [VA_W-1:0]       fault_vaddr
);
    localparam int PPN_W = PA_W - OFF_W;
    localparam int LVL_W = $clog2(LVL);
    localparam logic [LVL_W-1:0] LAST = LVL_W'(LVL - 1);

    walk_state_t           state, state_nx;
    logic [VA_W-1:0]       vaddr_q;
    logic [1:0]            acc_q;
    logic [PPN_W-1:0]      base_q;
    logic [LVL_W-1:0]      lvl_q;
    logic [FLAG_W-1:0]     flags_q;
    logic                  cause_q;
    logic                  leaf_ok;
    logic                  ent_valid;
    logic [PPN_W-1:0]      ent_ppn;
    logic [PA_W-1:0]       ent_addr;
    logic                  unused_rsv;

    assign ent_valid  = mem_rsp_data[FLG_V];
    assign ent_ppn    = mem_rsp_data[PTE_W-1 -: PPN_W];
    assign unused_rsv = ^mem_rsp_data[PTE_W-PPN_W-1:FLAG_W];

    ptw_slice #(
        .VA_W(VA_W), .LVL(LVL), .IDX_W(IDX_W), .OFF_W(OFF_W),
        .PA_W(PA_W), .ENT_BYTES(PTE_W/8)
    ) u_slice (
        .vaddr      (vaddr_q),
        .level      (lvl_q),
        .base_ppn   (base_q),
        .entry_addr (ent_addr)
    );

    ptw_perm u_perm (
        .acc     (acc_q),
        .rwx     (mem_rsp_data[FLG_X:FLG_R]),
        .allowed (leaf_ok)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = ST_ISSUE;
            ST_ISSUE: if (mem_req_ready) state_nx = ST_WAIT;
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!ent_valid)         state_nx = ST_FAULT;
                    else if (lvl_q != LAST) state_nx = ST_ISSUE;
                    else if (leaf_ok)       state_nx = ST_DONE;
                    else                    state_nx = ST_FAULT;
                end
            end
            ST_DONE:  state_nx = ST_IDLE;
            ST_FAULT: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // walk context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q <= '0;
            acc_q   <= '0;
            base_q  <= '0;
            lvl_q   <= '0;
            flags_q <= '0;
            cause_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        vaddr_q <= req_vaddr;
                        acc_q   <= req_acc;
                        base_q  <= root_ppn;
                        lvl_q   <= '0;
                    end
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        base_q  <= ent_ppn;
                        flags_q <= mem_rsp_data[FLAG_W-1:0];
                        cause_q <= ent_valid;
                        if (lvl_q != LAST) lvl_q <= lvl_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state == ST_IDLE);
        busy          = (state != ST_IDLE);
        mem_req_valid = (state == ST_ISSUE);
        mem_req_addr  = ent_addr;
        fill_valid    = (state == ST_DONE);
        fill_vpn      = vaddr_q[VA_W-1:OFF_W];
        fill_ppn      = base_q;
        fill_flags    = flags_q;
        fault_valid   = (state == ST_FAULT);
        fault_cause   = cause_q;
        fault_vaddr   = vaddr_q;
    end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int VA_W  = 52,
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    parameter int PA_W  = 64
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_ready,
    input logic [VA_W-1:0]       req_vaddr,
    input logic [PA_W-OFF_W-1:0] root_ppn,
    input logic                  busy,
    input logic                  mem_req_valid,
    input logic                  mem_req_ready,
    input logic [PA_W-1:0]       mem_req_addr,
    input logic                  fill_valid,
    input logic                  fault_valid
);
    logic [PA_W-1:0] first_addr;
    assign first_addr = {root_ppn, {OFF_W{1'b0}}}
                      + ({{(PA_W-IDX_W){1'b0}}, req_vaddr[VA_W-1 -: IDX_W]} << 3);

    // R2
    first_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> mem_req_valid && mem_req_addr == $past(first_addr));

    // R3
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready |=> !mem_req_valid);

    // R4
    fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |=> !fault_valid && req_ready);

    // R6
    fill_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> !fill_valid && req_ready);

    // R7
    single_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> busy && !req_ready);

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R9
    result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_valid && fault_valid));
endmodule

bind ptw_walker ptw_walker_chk #(
    .VA_W(VA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .root_ppn      (root_ppn),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .fill_valid    (fill_valid),
    .fault_valid   (fault_valid)
);

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [51:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic [51:0] root_ppn = '0;
    logic        busy;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        fill_valid;
    logic [39:0] fill_vpn;
    logic [51:0] fill_ppn;
    logic [4:0]  fill_flags;
    logic        fault_valid;
    logic        fault_cause;
    logic [51:0] fault_vaddr;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    logic [63:0] mem [logic [63:0]];
    logic [63:0] rd_log [$];

    bit          m_flt;
    bit          m_cause;
    logic [63:0] m_leaf;
    int          m_nrd;
    logic [63:0] m_addr [4];

    ptw_walker u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_acc(req_acc), .root_ppn(root_ppn), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
        .fill_ppn(fill_ppn), .fill_flags(fill_flags), .fault_valid(fault_valid),
        .fault_cause(fault_cause), .fault_vaddr(fault_vaddr)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    function automatic logic [63:0] rd_mem(input logic [63:0] a);
        if (mem.exists(a)) return mem[a];
        return 64'd0;
    endfunction

    function automatic logic [51:0] rnd52();
        return {$urandom(), $urandom()} & 64'h000F_FFFF_FFFF_FFFF;
    endfunction

    function automatic bit acc_ok(input logic [1:0] acc, input logic [63:0] e);
        case (acc)
            2'd1:    return e[2];
            2'd2:    return e[3];
            default: return e[1];
        endcase
    endfunction

    // reference walk over the bench memory
    task automatic model_walk(input logic [51:0] va, input logic [1:0] acc,
                              input logic [51:0] root);
        logic [51:0] base = root;
        m_flt = 0; m_cause = 0; m_nrd = 0; m_leaf = '0;
        for (int l = 0; l < 4; l++) begin
            logic [9:0]  idx = va[51-10*l -: 10];
            logic [63:0] a = {base, 12'd0} + {51'd0, idx, 3'd0};
            logic [63:0] e = rd_mem(a);
            m_addr[l] = a;
            m_nrd++;
            if (!e[0]) begin m_flt = 1; m_cause = 0; return; end
            if (l < 3) base = e[63:12];
            else begin
                m_leaf = e;
                if (!acc_ok(acc, e)) begin m_flt = 1; m_cause = 1; end
            end
        end
    endtask

    // fill memory with a table chain for va; bad_lvl < 0 means all valid
    task automatic build(input logic [51:0] va, input logic [51:0] root, input int bad_lvl,
                         input logic [4:0] leaf_flags, input logic [2:0] mid_rwx);
        logic [51:0] base = root;
        mem.delete();
        for (int l = 0; l < 4; l++) begin
            logic [63:0] a = {base, 12'd0} + {51'd0, va[51-10*l -: 10], 3'd0};
            logic [51:0] nxt = rnd52();
            if (l == bad_lvl) begin
                mem[a] = {nxt, 7'h55, 4'(l), 1'b0};
                return;
            end
            if (l < 3) mem[a] = {nxt, 7'd0, 1'b0, mid_rwx, 1'b1};
            else       mem[a] = {nxt, 7'd0, leaf_flags[4:1], 1'b1};
            base = nxt;
        end
    endtask

    // memory responder with random stalls and latency
    initial begin
        bit          hs = 0, pend = 0, prev_stall = 0;
        logic [63:0] lat_addr = '0, prev_addr = '0;
        int          cnt = 0;
        forever begin
            @(negedge clk);
            if (prev_stall)
                chk(mem_req_valid && mem_req_addr == prev_addr, "R8 held request",
                    mem_req_addr, prev_addr);
            mem_rsp_valid = 1'b0;
            if (hs) begin hs = 0; pend = 1; cnt = $urandom() % 3; end
            if (pend) begin
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rd_mem(lat_addr);
                    rd_log.push_back(lat_addr);
                    pend = 0;
                end else cnt--;
            end
            mem_req_ready = ($urandom() % 2) == 0;
            prev_stall = rst_n && mem_req_valid && !mem_req_ready;
            prev_addr  = mem_req_addr;
            if (rst_n && mem_req_valid && mem_req_ready) begin
                hs = 1; lat_addr = mem_req_addr;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hang expected=done");
        finish_run();
    end

    task automatic run_walk(input logic [51:0] va, input logic [1:0] acc,
                            input logic [51:0] root, input string tag);
        int  n = 0;
        bit  gate_ok = 1;
        model_walk(va, acc, root);
        rd_log.delete();
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_acc = acc; root_ppn = root;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_vaddr = rnd52(); root_ppn = rnd52();
        while (!(fill_valid || fault_valid) && n < 200) begin
            if (req_ready || !busy) gate_ok = 0;
            @(negedge clk);
            n++;
        end
        chk(gate_ok, {"R7 busy during walk ", tag}, {63'd0, gate_ok}, 64'd1);
        chk(!(fill_valid && fault_valid) && n < 200, {"R9 one result ", tag},
            {62'd0, fill_valid, fault_valid}, 64'd1);
        chk(rd_log.size() == m_nrd, {"R3 read count ", tag}, rd_log.size(), m_nrd);
        for (int i = 0; i < m_nrd && i < rd_log.size(); i++)
            chk(rd_log[i] == m_addr[i], {(i == 0) ? "R2 first addr " : "R3 level addr ", tag},
                rd_log[i], m_addr[i]);
        if (m_flt) begin
            chk(fault_valid && !fill_valid, {(m_cause ? "R5" : "R4"), " fault expected ", tag},
                {63'd0, fault_valid}, 64'd1);
            chk(fault_cause == m_cause, {(m_cause ? "R5" : "R4"), " cause ", tag},
                {63'd0, fault_cause}, {63'd0, m_cause});
            chk(fault_vaddr == va, {"R4 fault vaddr ", tag}, {12'd0, fault_vaddr}, {12'd0, va});
        end else begin
            chk(fill_valid && !fault_valid, {"R6 fill expected ", tag}, {63'd0, fill_valid}, 64'd1);
            chk(fill_vpn == va[51:12] && fill_ppn == m_leaf[63:12] && fill_flags == m_leaf[4:0],
                {"R6 fill fields ", tag}, {fill_ppn, 7'd0, fill_flags}, {m_leaf[63:12], 7'd0, m_leaf[4:0]});
        end
        @(negedge clk);
        chk(req_ready && !fill_valid && !fault_valid, {"R7 ready after result ", tag},
            {61'd0, req_ready, fill_valid, fault_valid}, 64'd4);
    endtask

    initial begin
        logic [51:0] va, rt;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(req_ready && !busy && !mem_req_valid && !fill_valid && !fault_valid, "R1 reset",
            {59'd0, req_ready, busy, mem_req_valid, fill_valid, fault_valid}, 64'h10);

        va = rnd52(); rt = rnd52();
        build(va, rt, 0, 5'h0f, 3'd0);
        run_walk(va, 2'd0, rt, "R4 level0 absent");
        va = rnd52();
        build(va, rt, 3, 5'h0f, 3'd0);
        run_walk(va, 2'd1, rt, "R4 leaf absent");
        va = rnd52();
        build(va, rt, -1, 5'h03, 3'd0);
        run_walk(va, 2'd1, rt, "R5 store on read-only");
        va = rnd52();
        build(va, rt, -1, 5'h09, 3'd0);
        run_walk(va, 2'd2, rt, "R5 fetch allowed");
        build(va, rt, -1, 5'h03, 3'd0);
        run_walk(va, 2'd3, rt, "R5 code3 as load ok");
        build(va, rt, -1, 5'h05, 3'd0);
        run_walk(va, 2'd3, rt, "R5 code3 no read bit");
        va = {52{1'b1}}; rt = {52{1'b1}};
        build(va, rt, -1, 5'h1f, 3'd0);
        run_walk(va, 2'd0, rt, "R2 all-ones index");
        va = rnd52(); rt = rnd52();
        build(va, rt, -1, 5'h03, 3'd7);
        run_walk(va, 2'd0, rt, "R10 nonleaf perms");

        for (int k = 0; k < 60; k++) begin
            int bad = (($urandom() % 4) == 0) ? int'($urandom() % 4) : -1;
            va = rnd52(); rt = rnd52();
            build(va, rt, bad, 5'($urandom()), 3'($urandom()));
            run_walk(va, 2'($urandom()), rt, "random");
        end
        finish_run();
    end
endmodule